// File: doc/BRIEF.md
# Configurable UART Framing Engine

This block is the bit-level serial engine that sits behind a UART register block. It takes a byte from a transmit FIFO and shifts it out on a serial line. It also watches the receive line, rebuilds incoming characters and writes each one, together with its error flags, into a receive FIFO. The FIFOs themselves stay outside the block. The engine reads the transmit FIFO through an empty flag, a data bus and a one-cycle pop strobe. It writes the receive FIFO through a full flag, an 11-bit entry bus and a one-cycle push strobe.

Bit timing comes from a 16-bit divisor that holds the 16x oversampling ratio minus one, so a divisor D gives one oversampling tick every D+1 clocks and one bit every 16×(D+1) clocks. The transmitter restarts its tick counter at each frame start, so its bit edges are exact. The receiver runs its tick counter freely, detects a start edge on a tick and samples every later bit in its centre. A configuration byte chooses the character length, the number of stop bits, whether a parity bit is present and its sense. The transmitter captures this byte at each frame start, and the receiver captures it at each validated start bit.

Top module: `uart_frame_engine`

## Requirements
- R1: With divisor D, every transmitted bit, including the start bit, lasts exactly 16×(D+1) clock cycles.
- R2: The line idles high. A frame is one low start bit followed by the data bits, least significant first. Config bit 0 set means 8 data bits and clear means 7.
- R3: Config bit 2 set adds one parity bit after the data. Config bit 4 then picks odd parity when set and even parity when clear. Even parity makes the count of ones across data and parity even, and odd parity makes it odd.
- R4: Config bit 1 set sends two high stop bits and clear sends one. Two back-to-back frames in two-stop mode keep the line high for both stop bit periods.
- R5: A frame starts only while tx_en is high and tx_fifo_empty is low. Each frame produces exactly one single-cycle tx_fifo_pop. tx_busy is high from the start bit through the last stop bit and low otherwise.
- R6: In 7-bit mode the transmitter never sends bit 7 of the FIFO byte, and the receiver stores bit 7 of the entry as 0.
- R7: The receiver confirms a start bit half a bit after the falling edge. A low pulse shorter than half a bit pushes nothing. Data, parity and stop bits are sampled once each at their centre.
- R8: An entry holds the character in bits 7:0, the parity error flag in bit 8, the framing error flag in bit 9 and the overrun flag in bit 10. It is written with a one-cycle rx_fifo_push. Bit 8 is set when the received parity bit disagrees with the configured parity.
- R9: Bit 9 of the entry is set when any expected stop bit is sampled low. This includes the second stop bit in two-stop mode.
- R10: A character that completes while rx_fifo_full is high is dropped without a push. The next entry that is pushed has bit 10 set, and later entries have it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Oversampling ratio minus one |
| cfg | input | 8 | Framing: bit0 8-bit, bit1 two stop, bit2 parity on, bit4 odd parity |
| tx_en | input | 1 | Allows new transmit frames to start |
| tx_fifo_empty | input | 1 | Transmit FIFO has no byte |
| tx_fifo_data | input | 8 | Byte at the head of the transmit FIFO |
| tx_fifo_pop | output | 1 | One-cycle strobe that takes the head byte |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmit frame in progress |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_fifo_full | input | 1 | Receive FIFO cannot accept an entry |
| rx_fifo_push | output | 1 | One-cycle write strobe for the receive FIFO |
| rx_fifo_entry | output | 11 | Overrun, framing error, parity error, character |

## Verification
The assertions assume that divisor and cfg stay constant while a frame is in flight in either direction, and that the head byte of the transmit FIFO is stable until it is popped. They also assume that rx_fifo_full changes only between clock edges, away from the character's completion. The stimulus changes the divisor and the framing only once both directions are idle. It models the transmit FIFO so that a byte leaves on the cycle of its pop strobe. It drives the receive line at exact bit periods measured from the clock, and it raises and lowers the full flag only while no character is completing.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int ENTRY_W = 11;

  typedef struct packed {
    logic odd;
    logic par_en;
    logic two_stop;
    logic eight;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  function automatic frame_cfg_t cfg_decode(input logic [7:0] c);
    frame_cfg_t f;
    f.odd      = c[4];
    f.par_en   = c[2];
    f.two_stop = c[1];
    f.eight    = c[0];
    return f;
  endfunction

  // parity bit value for a character under the chosen length and sense
  function automatic logic par_bit(input logic [7:0] d, input logic eight, input logic odd);
    logic [7:0] m;
    m = eight ? d : {1'b0, d[6:0]};
    return (^m) ^ odd;
  endfunction

endpackage

// File: rtl/uart_fe_tick.sv
module uart_fe_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= divisor) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (cnt_q >= divisor) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R1: after a tick, the next tick is at least two cycles away unless divisor is 0
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor != '0) |=> (!tick || divisor == '0));

endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  frame_cfg_t cfg_i,
  input  logic       tx_en,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       restart,
  output logic       pop,
  output logic       txd,
  output logic       busy
);

  localparam logic [3:0] LAST_TICK = 4'd15;

  phase_t     ph_q;
  logic [3:0] tcnt_q;
  logic [2:0] bitn_q;
  logic [7:0] sh_q;
  logic       eight_q, par_en_q, two_q, par_q, stopn_q;
  logic       launch;

  assign launch  = (ph_q == PH_IDLE) && tx_en && !fifo_empty;
  assign restart = launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      tcnt_q   <= '0;
      bitn_q   <= '0;
      sh_q     <= '0;
      eight_q  <= 1'b1;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
      par_q    <= 1'b0;
      stopn_q  <= 1'b0;
      pop      <= 1'b0;
      txd      <= 1'b1;
      busy     <= 1'b0;
    end else begin
      pop <= 1'b0;
      if (ph_q == PH_IDLE) begin
        txd  <= 1'b1;
        busy <= 1'b0;
        if (launch) begin
          pop      <= 1'b1;
          sh_q     <= fifo_data;
          eight_q  <= cfg_i.eight;
          par_en_q <= cfg_i.par_en;
          two_q    <= cfg_i.two_stop;
          par_q    <= par_bit(fifo_data, cfg_i.eight, cfg_i.odd);
          tcnt_q   <= '0;
          ph_q     <= PH_START;
          txd      <= 1'b0;
          busy     <= 1'b1;
        end
      end else if (tick) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (tcnt_q == LAST_TICK) begin
          unique case (ph_q)
            PH_START: begin
              ph_q   <= PH_DATA;
              bitn_q <= '0;
              txd    <= sh_q[0];
            end
            PH_DATA: begin
              if (bitn_q == (eight_q ? 3'd7 : 3'd6)) begin
                stopn_q <= 1'b0;
                if (par_en_q) begin
                  ph_q <= PH_PAR;
                  txd  <= par_q;
                end else begin
                  ph_q <= PH_STOP;
                  txd  <= 1'b1;
                end
              end else begin
                bitn_q <= bitn_q + 1'b1;
                sh_q   <= {1'b0, sh_q[7:1]};
                txd    <= sh_q[1];
              end
            end
            PH_PAR: begin
              ph_q <= PH_STOP;
              txd  <= 1'b1;
            end
            PH_STOP: begin
              if (stopn_q == two_q) begin
                ph_q <= PH_IDLE;
                busy <= 1'b0;
              end else begin
                stopn_q <= 1'b1;
              end
            end
            default: ph_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R2: line stays high whenever no frame is in progress
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R5: a pop only follows a cycle with enable set and data present
  p_pop_gate_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> ($past(tx_en) && !$past(fifo_empty)));
  // R5: pop is a single-cycle strobe
  p_pop_once_r5: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);
  // R5: the frame is under way in the cycle of its pop
  p_pop_busy_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> (busy && !txd));

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  frame_cfg_t         cfg_i,
  input  logic               rxd,
  input  logic               fifo_full,
  output logic               push,
  output logic [ENTRY_W-1:0] entry
);

  localparam logic [3:0] MID_TICK  = 4'd7;
  localparam logic [3:0] LAST_TICK = 4'd15;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  phase_t                 ph_q;
  frame_cfg_t             lcfg_q;
  logic [3:0]             tcnt_q;
  logic [2:0]             bitn_q;
  logic [7:0]             sh_q;
  logic                   last_q, perr_q, ferr_q, ovr_q, stopn_q;

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      lcfg_q  <= '0;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      last_q  <= 1'b1;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      stopn_q <= 1'b0;
      push    <= 1'b0;
      entry   <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (ph_q)
          PH_IDLE: begin
            last_q <= line;
            if (last_q && !line) begin
              ph_q   <= PH_START;
              tcnt_q <= '0;
            end
          end
          PH_START: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == MID_TICK) begin
              tcnt_q <= '0;
              if (line) begin
                ph_q   <= PH_IDLE;
                last_q <= 1'b1;
              end else begin
                ph_q   <= PH_DATA;
                bitn_q <= '0;
                sh_q   <= '0;
                lcfg_q <= cfg_i;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
              end
            end
          end
          PH_DATA: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == LAST_TICK) begin
              sh_q[bitn_q] <= line;
              if (bitn_q == (lcfg_q.eight ? 3'd7 : 3'd6)) begin
                stopn_q <= 1'b0;
                ph_q    <= lcfg_q.par_en ? PH_PAR : PH_STOP;
              end else begin
                bitn_q <= bitn_q + 1'b1;
              end
            end
          end
          PH_PAR: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == LAST_TICK) begin
              perr_q <= (line != par_bit(sh_q, lcfg_q.eight, lcfg_q.odd));
              ph_q   <= PH_STOP;
            end
          end
          PH_STOP: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == LAST_TICK) begin
              if (stopn_q == lcfg_q.two_stop) begin
                ph_q   <= PH_IDLE;
                last_q <= line;
                if (fifo_full) begin
                  ovr_q <= 1'b1;
                end else begin
                  push  <= 1'b1;
                  entry <= {ovr_q, ferr_q | !line, perr_q, sh_q};
                  ovr_q <= 1'b0;
                end
              end else begin
                ferr_q  <= ferr_q | !line;
                stopn_q <= 1'b1;
              end
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  // R10: nothing is written into a FIFO that reported full
  p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> !$past(fifo_full));
  // R8: push is a single-cycle strobe
  p_push_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
  // R6: 7-bit characters never carry a set bit 7
  p_bit7_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !lcfg_q.eight) |-> !entry[7]);

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [7:0]         cfg,
  input  logic               tx_en,
  input  logic               tx_fifo_empty,
  input  logic [7:0]         tx_fifo_data,
  output logic               tx_fifo_pop,
  output logic               txd,
  output logic               tx_busy,
  input  logic               rxd,
  input  logic               rx_fifo_full,
  output logic               rx_fifo_push,
  output logic [ENTRY_W-1:0] rx_fifo_entry
);

  frame_cfg_t fcfg;
  logic       tx_tick, rx_tick, tx_restart;
  logic       cfg_unused;

  assign fcfg       = cfg_decode(cfg);
  assign cfg_unused = ^{cfg[7:5], cfg[3]};

  uart_fe_tick #(.DIV_W(DIV_W)) u_tx_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (tx_restart),
    .divisor (divisor),
    .tick    (tx_tick)
  );

  uart_fe_tick #(.DIV_W(DIV_W)) u_rx_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (1'b0),
    .divisor (divisor),
    .tick    (rx_tick)
  );

  uart_fe_tx u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (tx_tick),
    .cfg_i      (fcfg),
    .tx_en      (tx_en),
    .fifo_empty (tx_fifo_empty),
    .fifo_data  (tx_fifo_data),
    .restart    (tx_restart),
    .pop        (tx_fifo_pop),
    .txd        (txd),
    .busy       (tx_busy)
  );

  uart_fe_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (rx_tick),
    .cfg_i     (fcfg),
    .rxd       (rxd),
    .fifo_full (rx_fifo_full),
    .push      (rx_fifo_push),
    .entry     (rx_fifo_entry)
  );

endmodule

// File: tb/uart_frame_engine_bench.sv
module uart_frame_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'd1;
  logic [7:0]  cfg = 8'h01;
  logic        tx_en = 1'b0;
  logic        tx_fifo_empty = 1'b1;
  logic [7:0]  tx_fifo_data = 8'h00;
  logic        tx_fifo_pop, txd, tx_busy;
  logic        rxd = 1'b1;
  logic        rx_fifo_full = 1'b0;
  logic        rx_fifo_push;
  logic [10:0] rx_fifo_entry;

  always #4 clk = ~clk;

  uart_frame_engine u_uart_frame_engine (
    .clk(clk), .rst(rst), .divisor(divisor), .cfg(cfg), .tx_en(tx_en),
    .tx_fifo_empty(tx_fifo_empty), .tx_fifo_data(tx_fifo_data),
    .tx_fifo_pop(tx_fifo_pop), .txd(txd), .tx_busy(tx_busy), .rxd(rxd),
    .rx_fifo_full(rx_fifo_full), .rx_fifo_push(rx_fifo_push),
    .rx_fifo_entry(rx_fifo_entry)
  );

  int total = 0;
  int bad = 0;
  int pops = 0;
  int pushes = 0;
  logic [7:0]  txq[$];
  logic [7:0]  tx_exp[$];
  logic [10:0] rx_exp[$];

  function automatic int bitlen();
    return 16 * (int'(divisor) + 1);
  endfunction

  function automatic logic [7:0] mk_cfg(input logic eight, input logic two,
                                        input logic par, input logic odd);
    return {3'b000, odd, 1'b0, par, two, eight};
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic eight,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < (eight ? 8 : 7); i++) p = p ^ d[i];
    return p;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // transmit FIFO model: head leaves on the pop strobe
  always @(negedge clk) begin
    if (tx_fifo_pop) begin
      pops++;
      if (txq.size() != 0) void'(txq.pop_front());
    end
    tx_fifo_empty <= (txq.size() == 0);
    tx_fifo_data  <= (txq.size() != 0) ? txq[0] : 8'h00;
  end

  // receive scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rx_fifo_push) begin
      pushes++;
      if (rx_exp.size() == 0) begin
        chk(1'b0, "R8 unexpected push", {21'd0, rx_fifo_entry}, 32'd0);
      end else begin
        logic [10:0] e;
        e = rx_exp.pop_front();
        chk(rx_fifo_entry == e, "R8/R9/R10 entry", {21'd0, rx_fifo_entry}, {21'd0, e});
      end
    end
  end

  // transmit line decoder
  task automatic decode_tx();
    int b;
    logic [7:0] got;
    logic eight, two, par, odd, pbit, s1, s2;
    logic [7:0] e;
    b = bitlen();
    eight = cfg[0]; two = cfg[1]; par = cfg[2]; odd = cfg[4];
    got = 8'h00;
    repeat (b / 2) @(negedge clk);
    chk(txd == 1'b0 && tx_busy, "R2/R5 start bit and busy", {30'd0, tx_busy, txd}, 32'h2);
    for (int i = 0; i < (eight ? 8 : 7); i++) begin
      repeat (b) @(negedge clk);
      got[i] = txd;
    end
    pbit = 1'b0;
    if (par) begin
      repeat (b) @(negedge clk);
      pbit = txd;
    end
    repeat (b) @(negedge clk);
    s1 = txd;
    s2 = 1'b1;
    if (two) begin
      repeat (b) @(negedge clk);
      s2 = txd;
    end
    e = (tx_exp.size() != 0) ? tx_exp.pop_front() : 8'hxx;
    if (!eight) e[7] = 1'b0;
    chk(got == e, eight ? "R2 tx data" : "R6 tx 7-bit data", {24'd0, got}, {24'd0, e});
    if (par)
      chk(pbit == parity_of(e, eight, odd), "R3 tx parity", {31'd0, pbit},
          {31'd0, parity_of(e, eight, odd)});
    chk(s1 && s2, "R4 tx stop bits", {30'd0, s2, s1}, 32'h3);
  endtask

  initial begin
    logic p;
    p = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && p && !txd) decode_tx();
      p = txd;
    end
  end

  task automatic send_tx(input logic [7:0] d);
    txq.push_back(d);
    tx_exp.push_back(d);
  endtask

  task automatic wait_tx_done();
    do @(negedge clk); while (txq.size() != 0 || tx_busy || tx_exp.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure_start(input logic [31:0] exp);
    int w;
    send_tx(8'h01);
    do @(negedge clk); while (txd);
    w = 0;
    while (!txd) begin
      w++;
      @(negedge clk);
    end
    chk(w == int'(exp), "R1 start bit width", w, exp);
    wait_tx_done();
  endtask

  // drive one frame on rxd and queue the expected entry
  task automatic send_rx(input logic [7:0] d, input logic bad_par, input logic bad_stop,
                         input logic full, input logic ovr);
    int b;
    logic eight, two, par, odd, pb;
    b = bitlen();
    eight = cfg[0]; two = cfg[1]; par = cfg[2]; odd = cfg[4];
    if (!full)
      rx_exp.push_back({ovr, bad_stop, bad_par & par, eight ? d[7] : 1'b0, d[6:0]});
    rxd = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < (eight ? 8 : 7); i++) begin
      rxd = d[i];
      repeat (b) @(negedge clk);
    end
    if (par) begin
      pb = parity_of(d, eight, odd) ^ bad_par;
      rxd = pb;
      repeat (b) @(negedge clk);
    end
    rxd = two ? 1'b1 : !bad_stop;
    repeat (b) @(negedge clk);
    if (two) begin
      rxd = !bad_stop;
      repeat (b) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * b) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R2, R5, R8)
    chk(txd == 1'b1, "R2 reset txd", {31'd0, txd}, 32'd1);
    chk(!tx_busy && !tx_fifo_pop, "R5 reset busy/pop", {30'd0, tx_busy, tx_fifo_pop}, 32'd0);
    chk(!rx_fifo_push, "R8 reset push", {31'd0, rx_fifo_push}, 32'd0);

    // R5: tx_en low holds a waiting byte
    divisor = 16'd1;
    cfg = mk_cfg(1, 0, 0, 0);
    send_tx(8'hA5);
    repeat (3 * bitlen()) @(negedge clk);
    chk(pops == 0 && txd && !tx_busy, "R5 tx_en gating", pops, 32'd0);
    tx_en = 1'b1;
    wait_tx_done();
    chk(pops == 1, "R5 one pop per frame", pops, 32'd1);

    // R1: bit length at two divisors
    measure_start(32'd32);

    // R3: even and odd parity, R4: two stop bits back to back
    cfg = mk_cfg(1, 0, 1, 0);
    send_tx(8'h3C); send_tx(8'h7F);
    wait_tx_done();
    cfg = mk_cfg(1, 1, 1, 1);
    send_tx(8'h00); send_tx(8'hFF); send_tx(8'h81);
    wait_tx_done();
    // R6: 7-bit transmit ignores bit 7
    cfg = mk_cfg(0, 0, 0, 0);
    send_tx(8'h3A); send_tx(8'hC5);
    wait_tx_done();
    cfg = mk_cfg(0, 0, 1, 0);
    send_tx(8'hC5);
    wait_tx_done();
    n = pops;
    chk(n == 10, "R5 total pops", n, 32'd10);

    divisor = 16'd3;
    cfg = mk_cfg(1, 0, 0, 0);
    measure_start(32'd64);
    send_tx(8'h5A);
    wait_tx_done();

    // receive side
    divisor = 16'd1;
    cfg = mk_cfg(1, 0, 0, 0);
    send_rx(8'h55, 0, 0, 0, 0);
    send_rx(8'hA3, 0, 0, 0, 0);
    cfg = mk_cfg(1, 0, 1, 0);
    send_rx(8'h96, 0, 0, 0, 0);
    send_rx(8'h96, 1, 0, 0, 0);   // R8 parity error
    cfg = mk_cfg(1, 0, 1, 1);
    send_rx(8'h0F, 0, 0, 0, 0);
    send_rx(8'h0F, 1, 0, 0, 0);   // R8 odd parity error
    cfg = mk_cfg(0, 0, 0, 0);
    send_rx(8'hBF, 0, 0, 0, 0);   // R6 7-bit receive
    cfg = mk_cfg(1, 0, 0, 0);
    send_rx(8'h42, 0, 1, 0, 0);   // R9 framing error
    cfg = mk_cfg(1, 1, 0, 0);
    send_rx(8'h24, 0, 1, 0, 0);   // R9 second stop low
    send_rx(8'h24, 0, 0, 0, 0);

    // R7: short low pulse is rejected
    cfg = mk_cfg(1, 0, 0, 0);
    n = pushes;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitlen()) @(negedge clk);
    chk(pushes == n, "R7 glitch rejected", pushes - n, 32'd0);

    // R10: overrun
    rx_fifo_full = 1'b1;
    n = pushes;
    send_rx(8'h11, 0, 0, 1, 0);
    chk(pushes == n, "R10 no push while full", pushes - n, 32'd0);
    rx_fifo_full = 1'b0;
    send_rx(8'h22, 0, 0, 0, 1);
    send_rx(8'h33, 0, 0, 0, 0);

    // R7 at another divisor
    divisor = 16'd3;
    repeat (40) @(negedge clk);
    send_rx(8'hC3, 0, 0, 0, 0);

    repeat (20) @(negedge clk);
    chk(rx_exp.size() == 0, "R8 all entries received", rx_exp.size(), 32'd0);
    chk(tx_exp.size() == 0, "R2 all frames sent", tx_exp.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule